// File: doc/BRIEF.md
# Tag-Matching Operand Station

A single-entry pipeline register for one instruction that also performs operand forwarding. An instruction arrives on an issue stream. For each operand it carries either a known value, such as an immediate or a value read from the register file, or the tag of the producer that will compute it. The entry then listens to several result broadcast buses. When a waiting operand sees its tag on a valid bus, it takes that bus's data and becomes ready.

When every operand is ready and the downstream controller is not stalling, the entry releases its contents. It presents a configurable number of result trios, each made of a value, a tag and a valid bit. Each trio takes its value from an operand chosen at issue, and its tag and enable from the issue word. The entry then frees itself. An `occupied` flag tells the controller whether an instruction is held.

The issue side is a valid/ready stream. A transfer happens on a clock edge where `iss_valid` and `iss_ready` are both high. `iss_ready` is high when the entry is empty, or when it releases in the same cycle, so instructions can flow back to back without a bubble. The release side is also a stream. `rel_valid` is the valid signal and `stall` is an inverted ready. While `stall` is high, nothing is released and the held contents do not change. `iss_valid` may be raised or dropped at any time. The issue fields only matter in a cycle where a transfer happens.

Top module: `fwd_hold_station`

## Requirements
- R1: After reset, `occupied`, `rel_valid` and every bit of `out_valid` are 0, and `iss_ready` is 1.
- R2: An issue transfer (`iss_valid` and `iss_ready` high at a clock edge) makes `occupied` 1 in the following cycle.
- R3: An operand issued with its `iss_op_rdy` bit set is ready at once and holds `iss_op_val`. No bus activity is needed for it.
- R4: A waiting operand takes `cdb_data[k]` when `cdb_valid[k]` is 1 and `cdb_tag[k]` equals its stored tag. It counts as ready from the next cycle on.
- R5: A bus with `cdb_valid` low, or with a tag that differs from the operand's stored tag, leaves that operand waiting. Its value is not changed.
- R6: When several buses match one waiting operand in the same cycle, the bus with the lowest index supplies the data.
- R7: A bus that matches the tag of an incoming operand in the issue cycle is captured by that operand, which is then ready in the next cycle.
- R8: `rel_valid` is 1 exactly when `occupied` is 1, every operand is ready and `stall` is 0. After a release with no new issue in the same cycle, `occupied` returns to 0.
- R9: While `stall` is 1, nothing is released, `occupied` stays 1 and the held operand values do not change.
- R10: Trio m drives the operand chosen by its `iss_out_sel` field (a field value of N_OPS or more picks operand 0), the destination tag issued for it, and `out_valid[m] = rel_valid & iss_out_en[m]`.
- R11: In a release cycle `iss_ready` is 1. An instruction issued in that cycle is held next, with `occupied` staying 1.
- R12: While the entry is occupied and not releasing, `iss_ready` is 0 and a raised `iss_valid` has no effect on the held contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue stream valid |
| iss_ready | output | 1 | Issue stream ready |
| iss_op_val | input | N_OPS*DATA_W | Per-operand value (used if the ready bit is set) |
| iss_op_tag | input | N_OPS*TAG_W | Per-operand producer tag |
| iss_op_rdy | input | N_OPS | Per-operand value-already-known flag |
| iss_out_tag | input | N_OUTS*TAG_W | Destination tag for each result trio |
| iss_out_en | input | N_OUTS | Enable for each result trio |
| iss_out_sel | input | N_OUTS*SEL_W | Operand index feeding each trio |
| cdb_valid | input | N_BUS | Broadcast bus valid bits |
| cdb_tag | input | N_BUS*TAG_W | Broadcast bus tags |
| cdb_data | input | N_BUS*DATA_W | Broadcast bus data |
| stall | input | 1 | Downstream stall (inverted release ready) |
| occupied | output | 1 | Entry holds an instruction |
| rel_valid | output | 1 | Release happens this cycle |
| out_val | output | N_OUTS*DATA_W | Trio values |
| out_tag | output | N_OUTS*TAG_W | Trio tags |
| out_valid | output | N_OUTS | Trio valid bits |

## Verification
The checker watches the handshake on every cycle: an issue is always followed by occupancy, a release always frees the entry unless a refill arrives, a stall always suppresses release and holds occupancy, trio valids never appear outside a release, and a busy entry never offers ready. Only the bench scenarios show the data path. These cover which bus value a waiting operand captures, the priority among buses, capture in the issue cycle, the operand selection behind each trio, and whether ignored broadcasts or blocked issues leave the held values unchanged.

// File: rtl/fwd_hold_pkg.sv
package fwd_hold_pkg;
  // Width of an index field that must hold at least one bit.
  function automatic int idx_w(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/fwd_bus_match.sv
// Priority tag comparator over all broadcast buses; lowest index wins.
module fwd_bus_match #(
  parameter int N_BUS  = 3,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic [TAG_W-1:0]        want_tag,
  input  logic [N_BUS-1:0]        cdb_valid,
  input  logic [N_BUS*TAG_W-1:0]  cdb_tag,
  input  logic [N_BUS*DATA_W-1:0] cdb_data,
  output logic                    hit,
  output logic [DATA_W-1:0]       hit_data
);
  logic [N_BUS-1:0] match;

  for (genvar k = 0; k < N_BUS; k++) begin : g_cmp
    assign match[k] = cdb_valid[k] && (cdb_tag[k*TAG_W +: TAG_W] == want_tag);
  end

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = N_BUS - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit      = 1'b1;
        hit_data = cdb_data[k*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/fwd_operand_slot.sv
// One operand: value, tag and ready flag, with bus snooping.
module fwd_operand_slot #(
  parameter int N_BUS  = 3,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    live,
  input  logic [DATA_W-1:0]       in_val,
  input  logic [TAG_W-1:0]        in_tag,
  input  logic                    in_rdy,
  input  logic [N_BUS-1:0]        cdb_valid,
  input  logic [N_BUS*TAG_W-1:0]  cdb_tag,
  input  logic [N_BUS*DATA_W-1:0] cdb_data,
  output logic [DATA_W-1:0]       val,
  output logic                    ready
);
  logic [TAG_W-1:0]  tag_q;
  logic [TAG_W-1:0]  look_tag;
  logic              hit;
  logic [DATA_W-1:0] hit_data;

  // One comparator serves both the issue cycle and the waiting phase.
  assign look_tag = load ? in_tag : tag_q;

  fwd_bus_match #(.N_BUS(N_BUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_match (
    .want_tag (look_tag),
    .cdb_valid(cdb_valid),
    .cdb_tag  (cdb_tag),
    .cdb_data (cdb_data),
    .hit      (hit),
    .hit_data (hit_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      val   <= '0;
      ready <= 1'b0;
    end else if (load) begin
      tag_q <= in_tag;
      if (in_rdy) begin
        val   <= in_val;
        ready <= 1'b1;
      end else if (hit) begin
        val   <= hit_data;
        ready <= 1'b1;
      end else begin
        val   <= '0;
        ready <= 1'b0;
      end
    end else if (live && !ready && hit) begin
      val   <= hit_data;
      ready <= 1'b1;
    end
  end
endmodule

// File: rtl/fwd_out_select.sv
// Builds the result trios from the held operands.
module fwd_out_select #(
  parameter int N_OPS  = 3,
  parameter int N_OUTS = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic [N_OPS*DATA_W-1:0]  op_val,
  input  logic [N_OUTS*SEL_W-1:0]  sel,
  input  logic [N_OUTS*TAG_W-1:0]  dtag,
  input  logic [N_OUTS-1:0]        den,
  input  logic                     fire,
  output logic [N_OUTS*DATA_W-1:0] out_val,
  output logic [N_OUTS*TAG_W-1:0]  out_tag,
  output logic [N_OUTS-1:0]        out_valid
);
  for (genvar m = 0; m < N_OUTS; m++) begin : g_trio
    logic [SEL_W-1:0] s;
    assign s = sel[m*SEL_W +: SEL_W];
    always_comb begin
      out_val[m*DATA_W +: DATA_W] = op_val[0 +: DATA_W];
      for (int n = 1; n < N_OPS; n++) begin
        if (int'(s) == n) out_val[m*DATA_W +: DATA_W] = op_val[n*DATA_W +: DATA_W];
      end
    end
    assign out_tag[m*TAG_W +: TAG_W] = dtag[m*TAG_W +: TAG_W];
    assign out_valid[m] = fire && den[m];
  end
endmodule

// File: rtl/fwd_hold_station.sv
module fwd_hold_station #(
  parameter int N_OPS  = 3,
  parameter int N_OUTS = 2,
  parameter int N_BUS  = 3,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int SEL_W = fwd_hold_pkg::idx_w(N_OPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_valid,
  output logic                     iss_ready,
  input  logic [N_OPS*DATA_W-1:0]  iss_op_val,
  input  logic [N_OPS*TAG_W-1:0]   iss_op_tag,
  input  logic [N_OPS-1:0]         iss_op_rdy,
  input  logic [N_OUTS*TAG_W-1:0]  iss_out_tag,
  input  logic [N_OUTS-1:0]        iss_out_en,
  input  logic [N_OUTS*SEL_W-1:0]  iss_out_sel,
  input  logic [N_BUS-1:0]         cdb_valid,
  input  logic [N_BUS*TAG_W-1:0]   cdb_tag,
  input  logic [N_BUS*DATA_W-1:0]  cdb_data,
  input  logic                     stall,
  output logic                     occupied,
  output logic                     rel_valid,
  output logic [N_OUTS*DATA_W-1:0] out_val,
  output logic [N_OUTS*TAG_W-1:0]  out_tag,
  output logic [N_OUTS-1:0]        out_valid
);
  logic                     load;
  logic [N_OPS-1:0]         op_ready;
  logic [N_OPS*DATA_W-1:0]  op_val;
  logic [N_OUTS*TAG_W-1:0]  dtag_q;
  logic [N_OUTS-1:0]        den_q;
  logic [N_OUTS*SEL_W-1:0]  sel_q;

  assign rel_valid = occupied && (&op_ready) && !stall;
  assign iss_ready = !occupied || rel_valid;
  assign load      = iss_valid && iss_ready;

  for (genvar n = 0; n < N_OPS; n++) begin : g_slot
    fwd_operand_slot #(.N_BUS(N_BUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .live     (occupied),
      .in_val   (iss_op_val[n*DATA_W +: DATA_W]),
      .in_tag   (iss_op_tag[n*TAG_W +: TAG_W]),
      .in_rdy   (iss_op_rdy[n]),
      .cdb_valid(cdb_valid),
      .cdb_tag  (cdb_tag),
      .cdb_data (cdb_data),
      .val      (op_val[n*DATA_W +: DATA_W]),
      .ready    (op_ready[n])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occupied <= 1'b0;
      dtag_q   <= '0;
      den_q    <= '0;
      sel_q    <= '0;
    end else if (load) begin
      occupied <= 1'b1;
      dtag_q   <= iss_out_tag;
      den_q    <= iss_out_en;
      sel_q    <= iss_out_sel;
    end else if (rel_valid) begin
      occupied <= 1'b0;
    end
  end

  fwd_out_select #(
    .N_OPS(N_OPS), .N_OUTS(N_OUTS), .TAG_W(TAG_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_out (
    .op_val   (op_val),
    .sel      (sel_q),
    .dtag     (dtag_q),
    .den      (den_q),
    .fire     (rel_valid),
    .out_val  (out_val),
    .out_tag  (out_tag),
    .out_valid(out_valid)
  );
endmodule

// File: rtl/fwd_hold_checker.sv
module fwd_hold_checker #(
  parameter int N_OUTS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic              stall,
  input logic              occupied,
  input logic              rel_valid,
  input logic [N_OUTS-1:0] out_valid
);
  AST_ISSUE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> occupied); // R2
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !iss_valid) |=> !occupied); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !rel_valid); // R9
  AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (occupied && stall) |=> occupied); // R9
  AST_TRIO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid != '0) |-> rel_valid); // R10
  AST_REFILL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> iss_ready); // R11
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (occupied && !rel_valid) |-> !iss_ready); // R12
endmodule

bind fwd_hold_station fwd_hold_checker #(.N_OUTS(N_OUTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iss_valid(iss_valid),
  .iss_ready(iss_ready),
  .stall    (stall),
  .occupied (occupied),
  .rel_valid(rel_valid),
  .out_valid(out_valid)
);

// File: tb/tb_fwd_hold_station.sv
`timescale 1ns/1ps
module tb_fwd_hold_station;
  localparam int NO = 3, NT = 2, NB = 3, DW = 16, TW = 4, SW = 2;

  logic clk = 0, rst_n = 0;
  logic iss_valid, iss_ready, stall, occupied, rel_valid;
  logic [NO*DW-1:0] iss_op_val;
  logic [NO*TW-1:0] iss_op_tag;
  logic [NO-1:0]    iss_op_rdy;
  logic [NT*TW-1:0] iss_out_tag;
  logic [NT-1:0]    iss_out_en;
  logic [NT*SW-1:0] iss_out_sel;
  logic [NB-1:0]    cdb_valid;
  logic [NB*TW-1:0] cdb_tag;
  logic [NB*DW-1:0] cdb_data;
  logic [NT*DW-1:0] out_val;
  logic [NT*TW-1:0] out_tag;
  logic [NT-1:0]    out_valid;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  fwd_hold_station #(.N_OPS(NO), .N_OUTS(NT), .N_BUS(NB), .DATA_W(DW), .TAG_W(TW)) dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    iss_valid = 0; iss_op_val = '0; iss_op_tag = '0; iss_op_rdy = '0;
    iss_out_tag = '0; iss_out_en = '0; iss_out_sel = '0;
    cdb_valid = '0; cdb_tag = '0; cdb_data = '0; stall = 0;
  endtask

  task automatic set_op(input int i, input logic [DW-1:0] v, input logic [TW-1:0] t, input logic r);
    iss_op_val[i*DW +: DW] = v; iss_op_tag[i*TW +: TW] = t; iss_op_rdy[i] = r;
  endtask

  task automatic set_out(input int m, input logic [SW-1:0] s, input logic [TW-1:0] t, input logic e);
    iss_out_sel[m*SW +: SW] = s; iss_out_tag[m*TW +: TW] = t; iss_out_en[m] = e;
  endtask

  task automatic set_bus(input int k, input logic v, input logic [TW-1:0] t, input logic [DW-1:0] d);
    cdb_valid[k] = v; cdb_tag[k*TW +: TW] = t; cdb_data[k*DW +: DW] = d;
  endtask

  task automatic t_reset();
    #1;
    check("R1 occupied", occupied, 0);
    check("R1 rel_valid", rel_valid, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 iss_ready", iss_ready, 1);
  endtask

  task automatic t_immediate();
    @(negedge clk); idle_inputs();
    iss_valid = 1;
    set_op(0, 16'h0011, 0, 1); set_op(1, 16'h0022, 0, 1); set_op(2, 16'h0033, 0, 1);
    set_out(0, 2, 4'h1, 1); set_out(1, 0, 4'h2, 1);
    #1 check("R2 ready when empty", iss_ready, 1);
    @(negedge clk); idle_inputs(); #1;
    check("R2 occupied", occupied, 1);
    check("R8 release", rel_valid, 1);
    check("R3/R10 trio0 val", out_val[0 +: DW], 16'h0033);
    check("R3/R10 trio1 val", out_val[DW +: DW], 16'h0011);
    check("R10 trio0 tag", out_tag[0 +: TW], 4'h1);
    check("R10 out_valid", out_valid, 2'b11);
    @(negedge clk); #1;
    check("R8 freed", occupied, 0);
  endtask

  task automatic t_capture();
    @(negedge clk); idle_inputs();
    iss_valid = 1;
    set_op(0, 16'h0001, 0, 1); set_op(1, 16'hdead, 4'h5, 0); set_op(2, 16'hbeef, 4'h7, 0);
    set_out(0, 1, 4'h3, 1); set_out(1, 2, 4'h4, 1);
    @(negedge clk); idle_inputs();
    set_bus(1, 1, 4'h9, 16'h9999); set_bus(0, 0, 4'h5, 16'h5555);
    #1 check("R8 waits for operands", rel_valid, 0);
    @(negedge clk); idle_inputs(); #1;
    check("R5 no capture", rel_valid, 0);
    check("R5 still occupied", occupied, 1);
    set_bus(2, 1, 4'h5, 16'h0a0a); set_bus(0, 1, 4'h7, 16'h0b0b);
    @(negedge clk); idle_inputs(); #1;
    check("R4 released", rel_valid, 1);
    check("R4 op1 value", out_val[0 +: DW], 16'h0a0a);
    check("R4 op2 value", out_val[DW +: DW], 16'h0b0b);
    @(negedge clk);
  endtask

  task automatic t_priority();
    @(negedge clk); idle_inputs();
    iss_valid = 1;
    set_op(0, 16'h0100, 0, 1); set_op(1, 0, 4'h3, 0); set_op(2, 16'h0300, 0, 1);
    set_out(0, 1, 4'h6, 1); set_out(1, 1, 4'h6, 0);
    @(negedge clk); idle_inputs();
    set_bus(2, 1, 4'h3, 16'h3333); set_bus(1, 1, 4'h3, 16'h2222); set_bus(0, 1, 4'h3, 16'h1111);
    @(negedge clk); idle_inputs(); #1;
    check("R6 lowest bus wins", out_val[0 +: DW], 16'h1111);
    check("R10 enable low", out_valid, 2'b01);
    @(negedge clk);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); idle_inputs();
    iss_valid = 1;
    set_op(0, 16'h0007, 0, 1); set_op(1, 0, 4'h4, 0); set_op(2, 16'h0009, 0, 1);
    set_out(0, 1, 4'h2, 1); set_out(1, 3, 4'h8, 1);
    set_bus(2, 1, 4'h4, 16'h4444);
    @(negedge clk); idle_inputs(); #1;
    check("R7 issue-cycle capture", rel_valid, 1);
    check("R7 value", out_val[0 +: DW], 16'h4444);
    check("R10 out of range sel", out_val[DW +: DW], 16'h0007);
    check("R10 trio1 tag", out_tag[TW +: TW], 4'h8);
    @(negedge clk);
  endtask

  task automatic t_stall();
    @(negedge clk); idle_inputs();
    iss_valid = 1; stall = 1;
    set_op(0, 16'haaaa, 0, 1); set_op(1, 16'hbbbb, 0, 1); set_op(2, 16'hcccc, 0, 1);
    set_out(0, 0, 4'h1, 1); set_out(1, 2, 4'h2, 1);
    @(negedge clk); idle_inputs(); stall = 1;
    iss_valid = 1;
    set_op(0, 16'h1234, 0, 1); set_op(2, 16'h5678, 0, 1); set_out(0, 1, 4'hf, 1);
    #1;
    check("R9 no release", rel_valid, 0);
    check("R12 not ready", iss_ready, 0);
    @(negedge clk); #1;
    check("R9 held", occupied, 1);
    idle_inputs(); #1;
    check("R9/R12 release", rel_valid, 1);
    check("R12 op0 unchanged", out_val[0 +: DW], 16'haaaa);
    check("R12 op2 unchanged", out_val[DW +: DW], 16'hcccc);
    check("R12 tag unchanged", out_tag[0 +: TW], 4'h1);
    @(negedge clk); #1;
    check("R8 freed after stall", occupied, 0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk); idle_inputs();
    iss_valid = 1;
    set_op(0, 16'h0aa0, 0, 1); set_op(1, 16'h0bb0, 0, 1); set_op(2, 16'h0cc0, 0, 1);
    set_out(0, 0, 4'h1, 1); set_out(1, 1, 4'h2, 1);
    @(negedge clk);
    set_op(0, 16'h1aa1, 0, 1); set_op(1, 16'h1bb1, 0, 1); set_op(2, 16'h1cc1, 0, 1);
    set_out(0, 2, 4'h5, 1);
    #1;
    check("R11 ready while releasing", iss_ready, 1);
    check("R11 first value", out_val[0 +: DW], 16'h0aa0);
    @(negedge clk); idle_inputs(); #1;
    check("R11 still occupied", occupied, 1);
    check("R11 second value", out_val[0 +: DW], 16'h1cc1);
    check("R11 second tag", out_tag[0 +: TW], 4'h5);
    @(negedge clk); #1;
    check("R8 drained", occupied, 0);
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_immediate();
    t_capture();
    t_priority();
    t_same_cycle();
    t_stall();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #50000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule